// File: doc/BRIEF.md
# Complex Instruction Micro-Op Cracker

This block sits between an instruction decoder and an execution back end. It takes in one pre-decoded complex instruction record at a time, together with its class, ALU opcode, two register specifiers, a base register, a direction flag and a 32-bit immediate. It turns that record into a short, fixed sequence of simple micro-operations and sends them out one per cycle on a valid/ready stream. Each micro-op carries a kind, an ALU opcode, a destination, two sources and an immediate. The last element of each sequence is flagged.

Register-to-register work becomes a single micro-op. Instructions that read or write memory become load/compute/store sequences. Stack operations (push, call, return) become stack-pointer sequences. Values that only live inside a sequence pass through a temporary register that no architectural register number can reach. Sequences of up to four micro-ops come from hard-wired logic. The one longer sequence, a five-step block-copy element, is read from a small template table. While a sequence is in flight, the input is stalled. A new record can be taken in the same cycle as the final micro-op of the previous one.

Top module: `uop_cracker`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A record is taken on a rising edge where `in_valid` and `in_ready` are both 1. Its first micro-op is presented in the next cycle. `in_ready` stays 0 while a non-final micro-op is presented.
- R3: While `out_valid` is 1 and `out_ready` is 0, every micro-op output holds its value into the next cycle.
- R4: Encodings:
  - Record classes: 0 reg-reg ALU, 1 compare, 2 branch, 3 memory ALU, 4 push, 5 call, 6 return, 7 block-copy element.
  - Micro-op kinds: 0 load (`dst <= mem[srca+imm]`), 1 store (`mem[srca+imm] <= srcb`), 2 ALU (`dst <= srca op srcb`), 3 add-immediate (`dst <= srca+imm`), 4 jump (target `srca+imm`, or `imm` when `srca` is none), 5 read-PC (`dst <= pc`).
  - In 5-bit register fields, architectural register r is {0,r}, the temporary is 16 and "none" is 31. The stack pointer is architectural register 4 and the stack step is 4 bytes.
  - Fields a micro-op does not use are none (registers) or 0 (immediate). `out_aluop` is 0 on every kind other than ALU.
- R5: Classes 0, 1 and 2 give one micro-op each:
  - Class 0 gives ALU dst=rd, srca=rd, srcb=rs.
  - Class 1 gives the same ALU micro-op with dst=none.
  - Class 2 gives a jump with srca=none and imm=target.
- R6: Class 3 with `in_memdst`=0 gives two micro-ops:
  - a load of the temporary from [base+imm];
  - then ALU rd <= rd op temporary.
- R7: Class 3 with `in_memdst`=1 gives three micro-ops:
  - a load of the temporary from [base+imm];
  - ALU temporary <= temporary op rd;
  - a store of the temporary to [base+imm].
- R8: Class 4 gives two micro-ops:
  - a store of rd to [sp-4];
  - then add-immediate sp <= sp + (-4).
- R9: Class 5 gives four micro-ops:
  - read-PC into the temporary;
  - store of the temporary to [sp-4];
  - add-immediate sp <= sp + (-4);
  - jump with srca=none and imm=target.
- R10: Class 6 gives three micro-ops:
  - add-immediate sp <= sp+4;
  - load of the temporary from [sp-4];
  - jump with srca=temporary and imm=0.
- R11: Class 7 gives five micro-ops from the template table:
  - load of the temporary from [base+0];
  - store of the temporary to [rd+0];
  - base <= base+4;
  - rd <= rd+4;
  - rs <= rs + (-1).
- R12: `out_last` is 1 on the final micro-op of each sequence and 0 on all others. After the final micro-op is accepted with no new record taken, `out_valid` is 0.
- R13: A record offered while the final micro-op of the previous sequence is being accepted is taken in that same cycle. Its first micro-op follows in the next cycle with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Record offered |
| in_ready | output | 1 | Record can be taken |
| in_class | input | 3 | Record class |
| in_aluop | input | 4 | ALU opcode for compute steps |
| in_rd | input | 4 | First register operand |
| in_rs | input | 4 | Second register operand |
| in_base | input | 4 | Memory base register |
| in_memdst | input | 1 | 1: memory is the destination of a class-3 record |
| in_imm | input | 32 | Displacement or jump target |
| out_valid | output | 1 | Micro-op presented |
| out_ready | input | 1 | Downstream accepts the micro-op |
| out_kind | output | 3 | Micro-op kind |
| out_aluop | output | 4 | ALU opcode (0 for non-ALU kinds) |
| out_dst | output | 5 | Destination register code |
| out_srca | output | 5 | First source / address base code |
| out_srcb | output | 5 | Second source / store data code |
| out_imm | output | 32 | Immediate or offset |
| out_last | output | 1 | Final micro-op of the sequence |

## Verification
Every class is sent in isolation, and class 3 is sent with both direction values. This separates the one-, two- and three-step shapes and shows whether the temporary is wired as destination or as source in each step. Records that name register 15 and register 0, or that push the stack pointer itself, show whether specifier fields are swapped or truncated. The call sequence is run again under a held-off `out_ready` to separate stall handling from sequencing. Two single-step records are sent back to back to show whether the same-cycle handover leaves a gap or drops a record.

// File: rtl/uopc_pkg.sv
package uopc_pkg;

    localparam int REG_W    = 4;
    localparam int UREG_W   = REG_W + 1;
    localparam int ALU_W    = 4;
    localparam int DATA_W   = 32;
    localparam int MAX_UOPS = 8;
    localparam int IDX_W    = $clog2(MAX_UOPS);
    localparam int HW_MAX   = 4;
    localparam int TBL_DEPTH = 8;
    localparam int TBL_AW   = $clog2(TBL_DEPTH);

    typedef enum logic [2:0] {
        C_RR     = 3'd0,
        C_CMP    = 3'd1,
        C_BR     = 3'd2,
        C_MEMALU = 3'd3,
        C_PUSH   = 3'd4,
        C_CALL   = 3'd5,
        C_RET    = 3'd6,
        C_BLKMOV = 3'd7
    } icls_t;

    typedef enum logic [2:0] {
        K_LOAD  = 3'd0,
        K_STORE = 3'd1,
        K_ALU   = 3'd2,
        K_ADDI  = 3'd3,
        K_JUMP  = 3'd4,
        K_RDPC  = 3'd5
    } ukind_t;

    typedef logic [UREG_W-1:0] ureg_t;

    localparam ureg_t TMP_REG = ureg_t'(1) << REG_W;
    localparam ureg_t NO_REG  = '1;

    typedef struct packed {
        icls_t              cls;
        logic [ALU_W-1:0]   aluop;
        logic [REG_W-1:0]   rd;
        logic [REG_W-1:0]   rs;
        logic [REG_W-1:0]   base;
        logic               memdst;
        logic [DATA_W-1:0]  imm;
    } irec_t;

    typedef struct packed {
        ukind_t             kind;
        logic [ALU_W-1:0]   aluop;
        ureg_t              dst;
        ureg_t              srca;
        ureg_t              srcb;
        logic [DATA_W-1:0]  imm;
    } uop_t;

    // operand selectors used by the sequence template table
    typedef enum logic [2:0] {
        RS_NONE, RS_TMP, RS_RD, RS_RS, RS_BASE, RS_SP
    } rsel_t;

    typedef enum logic [2:0] {
        IS_ZERO, IS_DISP, IS_PSTEP, IS_NSTEP, IS_MONE
    } isel_t;

    typedef struct packed {
        ukind_t kind;
        rsel_t  dst;
        rsel_t  srca;
        rsel_t  srcb;
        isel_t  imm;
    } tmpl_t;

    function automatic ureg_t arch_reg(input logic [REG_W-1:0] r);
        return {1'b0, r};
    endfunction

    function automatic logic [IDX_W:0] seq_len(input irec_t r);
        case (r.cls)
            C_MEMALU: return r.memdst ? (IDX_W+1)'(3) : (IDX_W+1)'(2);
            C_PUSH:   return (IDX_W+1)'(2);
            C_CALL:   return (IDX_W+1)'(4);
            C_RET:    return (IDX_W+1)'(3);
            C_BLKMOV: return (IDX_W+1)'(5);
            default:  return (IDX_W+1)'(1);
        endcase
    endfunction

    function automatic uop_t mk_uop(input ukind_t k, input logic [ALU_W-1:0] op,
                                    input ureg_t d, input ureg_t a, input ureg_t b,
                                    input logic [DATA_W-1:0] im);
        uop_t u;
        u.kind  = k;
        u.aluop = op;
        u.dst   = d;
        u.srca  = a;
        u.srcb  = b;
        u.imm   = im;
        return u;
    endfunction

endpackage

// File: rtl/uopc_seq.sv
module uopc_seq
    import uopc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  irec_t              in_rec,
    output logic               in_ready,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_last,
    output irec_t              cur_rec,
    output logic [IDX_W-1:0]   cur_idx
);

    logic               busy_q;
    logic [IDX_W-1:0]   idx_q;
    irec_t              rec_q;
    logic [IDX_W:0]     len;
    logic               at_last;
    logic               fire;
    logic               accept;

    assign len      = seq_len(rec_q);
    assign at_last  = busy_q && ({1'b0, idx_q} == (len - (IDX_W+1)'(1)));
    assign fire     = busy_q && out_ready;
    assign in_ready = !busy_q || (fire && at_last);
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            rec_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            rec_q  <= in_rec;
        end else if (fire) begin
            if (at_last) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assign out_valid = busy_q;
    assign out_last  = at_last;
    assign cur_rec   = rec_q;
    assign cur_idx   = idx_q;

endmodule

// File: rtl/uopc_hardwired.sv
module uopc_hardwired
    import uopc_pkg::*;
#(
    parameter int SP_REG     = 4,
    parameter int WORD_BYTES = 4
)(
    input  irec_t              rec,
    input  logic [IDX_W-1:0]   idx,
    output uop_t               uop
);

    localparam logic [DATA_W-1:0] STEP  = DATA_W'(WORD_BYTES);
    localparam logic [DATA_W-1:0] NSTEP = -STEP;
    localparam ureg_t             SP    = ureg_t'(SP_REG);

    ureg_t rd_u, rs_u, base_u;

    assign rd_u   = arch_reg(rec.rd);
    assign rs_u   = arch_reg(rec.rs);
    assign base_u = arch_reg(rec.base);

    always_comb begin
        uop = mk_uop(K_ALU, '0, NO_REG, NO_REG, NO_REG, '0);
        case (rec.cls)
            C_RR:  uop = mk_uop(K_ALU, rec.aluop, rd_u, rd_u, rs_u, '0);
            C_CMP: uop = mk_uop(K_ALU, rec.aluop, NO_REG, rd_u, rs_u, '0);
            C_BR:  uop = mk_uop(K_JUMP, '0, NO_REG, NO_REG, NO_REG, rec.imm);
            C_MEMALU: begin
                case (idx)
                    IDX_W'(0): uop = mk_uop(K_LOAD, '0, TMP_REG, base_u, NO_REG, rec.imm);
                    IDX_W'(1): begin
                        if (rec.memdst)
                            uop = mk_uop(K_ALU, rec.aluop, TMP_REG, TMP_REG, rd_u, '0);
                        else
                            uop = mk_uop(K_ALU, rec.aluop, rd_u, rd_u, TMP_REG, '0);
                    end
                    default:   uop = mk_uop(K_STORE, '0, NO_REG, base_u, TMP_REG, rec.imm);
                endcase
            end
            C_PUSH: begin
                if (idx == IDX_W'(0))
                    uop = mk_uop(K_STORE, '0, NO_REG, SP, rd_u, NSTEP);
                else
                    uop = mk_uop(K_ADDI, '0, SP, SP, NO_REG, NSTEP);
            end
            C_CALL: begin
                case (idx)
                    IDX_W'(0): uop = mk_uop(K_RDPC, '0, TMP_REG, NO_REG, NO_REG, '0);
                    IDX_W'(1): uop = mk_uop(K_STORE, '0, NO_REG, SP, TMP_REG, NSTEP);
                    IDX_W'(2): uop = mk_uop(K_ADDI, '0, SP, SP, NO_REG, NSTEP);
                    default:   uop = mk_uop(K_JUMP, '0, NO_REG, NO_REG, NO_REG, rec.imm);
                endcase
            end
            C_RET: begin
                case (idx)
                    IDX_W'(0): uop = mk_uop(K_ADDI, '0, SP, SP, NO_REG, STEP);
                    IDX_W'(1): uop = mk_uop(K_LOAD, '0, TMP_REG, SP, NO_REG, NSTEP);
                    default:   uop = mk_uop(K_JUMP, '0, NO_REG, TMP_REG, NO_REG, '0);
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/uopc_table.sv
module uopc_table
    import uopc_pkg::*;
#(
    parameter int SP_REG     = 4,
    parameter int WORD_BYTES = 4
)(
    input  irec_t              rec,
    input  logic [IDX_W-1:0]   idx,
    output uop_t               uop
);

    localparam logic [DATA_W-1:0] STEP  = DATA_W'(WORD_BYTES);
    localparam ureg_t             SP    = ureg_t'(SP_REG);

    // first table row of each long sequence
    function automatic logic [TBL_AW-1:0] tbl_base(input icls_t c);
        case (c)
            C_BLKMOV: return TBL_AW'(0);
            default:  return TBL_AW'(0);
        endcase
    endfunction

    function automatic tmpl_t tbl_row(input logic [TBL_AW-1:0] a);
        tmpl_t t;
        t = '{kind: K_ALU, dst: RS_NONE, srca: RS_NONE, srcb: RS_NONE, imm: IS_ZERO};
        case (a)
            TBL_AW'(0): t = '{kind: K_LOAD,  dst: RS_TMP,  srca: RS_BASE, srcb: RS_NONE, imm: IS_ZERO};
            TBL_AW'(1): t = '{kind: K_STORE, dst: RS_NONE, srca: RS_RD,   srcb: RS_TMP,  imm: IS_ZERO};
            TBL_AW'(2): t = '{kind: K_ADDI,  dst: RS_BASE, srca: RS_BASE, srcb: RS_NONE, imm: IS_PSTEP};
            TBL_AW'(3): t = '{kind: K_ADDI,  dst: RS_RD,   srca: RS_RD,   srcb: RS_NONE, imm: IS_PSTEP};
            TBL_AW'(4): t = '{kind: K_ADDI,  dst: RS_RS,   srca: RS_RS,   srcb: RS_NONE, imm: IS_MONE};
            default: ;
        endcase
        return t;
    endfunction

    function automatic ureg_t pick_reg(input rsel_t s, input irec_t r);
        case (s)
            RS_TMP:  return TMP_REG;
            RS_RD:   return arch_reg(r.rd);
            RS_RS:   return arch_reg(r.rs);
            RS_BASE: return arch_reg(r.base);
            RS_SP:   return SP;
            default: return NO_REG;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pick_imm(input isel_t s, input irec_t r);
        case (s)
            IS_DISP:  return r.imm;
            IS_PSTEP: return STEP;
            IS_NSTEP: return -STEP;
            IS_MONE:  return '1;
            default:  return '0;
        endcase
    endfunction

    tmpl_t              row;
    logic [TBL_AW-1:0]  addr;

    assign addr = tbl_base(rec.cls) + TBL_AW'(idx);
    assign row  = tbl_row(addr);

    always_comb begin
        uop.kind  = row.kind;
        uop.aluop = '0;
        uop.dst   = pick_reg(row.dst, rec);
        uop.srca  = pick_reg(row.srca, rec);
        uop.srcb  = pick_reg(row.srcb, rec);
        uop.imm   = pick_imm(row.imm, rec);
    end

endmodule

// File: rtl/uop_cracker.sv
module uop_cracker
    import uopc_pkg::*;
#(
    parameter int SP_REG     = 4,
    parameter int WORD_BYTES = 4
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [2:0]           in_class,
    input  logic [ALU_W-1:0]     in_aluop,
    input  logic [REG_W-1:0]     in_rd,
    input  logic [REG_W-1:0]     in_rs,
    input  logic [REG_W-1:0]     in_base,
    input  logic                 in_memdst,
    input  logic [DATA_W-1:0]    in_imm,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [2:0]           out_kind,
    output logic [ALU_W-1:0]     out_aluop,
    output logic [UREG_W-1:0]    out_dst,
    output logic [UREG_W-1:0]    out_srca,
    output logic [UREG_W-1:0]    out_srcb,
    output logic [DATA_W-1:0]    out_imm,
    output logic                 out_last
);

    irec_t              in_rec;
    irec_t              cur_rec;
    logic [IDX_W-1:0]   cur_idx;
    uop_t               hw_uop;
    uop_t               tb_uop;
    uop_t               sel_uop;
    logic               use_table;

    always_comb begin
        in_rec.cls    = icls_t'(in_class);
        in_rec.aluop  = in_aluop;
        in_rec.rd     = in_rd;
        in_rec.rs     = in_rs;
        in_rec.base   = in_base;
        in_rec.memdst = in_memdst;
        in_rec.imm    = in_imm;
    end

    uopc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_rec    (in_rec),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_last  (out_last),
        .cur_rec   (cur_rec),
        .cur_idx   (cur_idx)
    );

    uopc_hardwired #(.SP_REG(SP_REG), .WORD_BYTES(WORD_BYTES)) u_hw (
        .rec (cur_rec),
        .idx (cur_idx),
        .uop (hw_uop)
    );

    uopc_table #(.SP_REG(SP_REG), .WORD_BYTES(WORD_BYTES)) u_tbl (
        .rec (cur_rec),
        .idx (cur_idx),
        .uop (tb_uop)
    );

    assign use_table = seq_len(cur_rec) > (IDX_W+1)'(HW_MAX);
    assign sel_uop   = use_table ? tb_uop : hw_uop;

    assign out_kind  = sel_uop.kind;
    assign out_aluop = sel_uop.aluop;
    assign out_dst   = sel_uop.dst;
    assign out_srca  = sel_uop.srca;
    assign out_srcb  = sel_uop.srcb;
    assign out_imm   = sel_uop.imm;

endmodule

// File: rtl/uopc_checker.sv
module uopc_checker
    import uopc_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [2:0]           in_class,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [2:0]           out_kind,
    input logic [ALU_W-1:0]     out_aluop,
    input logic [UREG_W-1:0]    out_dst,
    input logic [UREG_W-1:0]    out_srca,
    input logic [UREG_W-1:0]    out_srcb,
    input logic [DATA_W-1:0]    out_imm,
    input logic                 out_last
);

    assert_first_next_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    assert_ready_low_midseq_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |-> !in_ready);

    assert_hold_under_stall_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_aluop)
            && $stable(out_dst) && $stable(out_srca) && $stable(out_srcb)
            && $stable(out_imm) && $stable(out_last)));

    assert_aluop_zero_nonalu_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind != 3'd2) |-> (out_aluop == '0));

    assert_memalu_starts_load_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_class == 3'd3) |=> (out_kind == 3'd0 && out_dst == TMP_REG));

    assert_call_starts_rdpc_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_class == 3'd5) |=> (out_kind == 3'd5));

    assert_idle_after_last_R12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last && !(in_valid && in_ready)) |=> !out_valid);

endmodule

bind uop_cracker uopc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_class  (in_class),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_kind  (out_kind),
    .out_aluop (out_aluop),
    .out_dst   (out_dst),
    .out_srca  (out_srca),
    .out_srcb  (out_srcb),
    .out_imm   (out_imm),
    .out_last  (out_last)
);

// File: tb/tb_uop_cracker.sv
module tb_uop_cracker;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 11;

    // record layout: class[51:49] aluop[48:45] rd[44:41] rs[40:37] base[36:33] memdst[32] imm[31:0]
    localparam logic [51:0] VECS [NVEC] = '{
        {3'd0, 4'd3,  4'd1,  4'd2,  4'd0,  1'b0, 32'h0000_0000},
        {3'd1, 4'd5,  4'd7,  4'd8,  4'd0,  1'b0, 32'h0000_0000},
        {3'd2, 4'd0,  4'd0,  4'd0,  4'd0,  1'b0, 32'h0000_1200},
        {3'd3, 4'd1,  4'd3,  4'd0,  4'd6,  1'b0, 32'h0000_0010},
        {3'd3, 4'd2,  4'd5,  4'd0,  4'd9,  1'b1, 32'hFFFF_FFF8},
        {3'd4, 4'd0,  4'd11, 4'd0,  4'd0,  1'b0, 32'h0000_0000},
        {3'd5, 4'd0,  4'd0,  4'd0,  4'd0,  1'b0, 32'h0004_0000},
        {3'd6, 4'd0,  4'd0,  4'd0,  4'd0,  1'b0, 32'h0000_0000},
        {3'd7, 4'd0,  4'd12, 4'd13, 4'd14, 1'b0, 32'h0000_0000},
        {3'd0, 4'd15, 4'd15, 4'd0,  4'd0,  1'b0, 32'h0000_0000},
        {3'd4, 4'd0,  4'd4,  4'd0,  4'd0,  1'b0, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [2:0]  in_class;
    logic [3:0]  in_aluop, in_rd, in_rs, in_base;
    logic        in_memdst;
    logic [31:0] in_imm;
    logic        out_valid;
    logic        out_ready;
    logic [2:0]  out_kind;
    logic [3:0]  out_aluop;
    logic [4:0]  out_dst, out_srca, out_srcb;
    logic [31:0] out_imm;
    logic        out_last;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uop_cracker dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_class(in_class),
        .in_aluop(in_aluop), .in_rd(in_rd), .in_rs(in_rs), .in_base(in_base),
        .in_memdst(in_memdst), .in_imm(in_imm),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_aluop(out_aluop), .out_dst(out_dst), .out_srca(out_srca),
        .out_srcb(out_srcb), .out_imm(out_imm), .out_last(out_last)
    );

    localparam logic [4:0]  T_R  = 5'd16;
    localparam logic [4:0]  N_R  = 5'd31;
    localparam logic [4:0]  SP_R = 5'd4;
    localparam logic [31:0] PS   = 32'd4;
    localparam logic [31:0] NS   = 32'hFFFF_FFFC;

    function automatic int exp_len(input logic [51:0] v);
        case (v[51:49])
            3'd3:    return v[32] ? 3 : 2;
            3'd4:    return 2;
            3'd5:    return 4;
            3'd6:    return 3;
            3'd7:    return 5;
            default: return 1;
        endcase
    endfunction

    function automatic string req_tag(input logic [51:0] v);
        case (v[51:49])
            3'd3:    return v[32] ? "R7" : "R6";
            3'd4:    return "R8";
            3'd5:    return "R9";
            3'd6:    return "R10";
            3'd7:    return "R11";
            default: return "R5";
        endcase
    endfunction

    // expected {kind, aluop, dst, srca, srcb, imm, last}
    function automatic logic [54:0] exp_uop(input logic [51:0] v, input int i);
        logic [3:0]  op;
        logic [4:0]  rd, rs, bs;
        logic [31:0] im;
        logic [53:0] u;
        op = v[48:45];
        rd = {1'b0, v[44:41]};
        rs = {1'b0, v[40:37]};
        bs = {1'b0, v[36:33]};
        im = v[31:0];
        u  = '0;
        case (v[51:49])
            3'd0: u = {3'd2, op, rd, rd, rs, 32'd0};
            3'd1: u = {3'd2, op, N_R, rd, rs, 32'd0};
            3'd2: u = {3'd4, 4'd0, N_R, N_R, N_R, im};
            3'd3: begin
                if (i == 0)        u = {3'd0, 4'd0, T_R, bs, N_R, im};
                else if (i == 1)   u = v[32] ? {3'd2, op, T_R, T_R, rd, 32'd0}
                                             : {3'd2, op, rd, rd, T_R, 32'd0};
                else               u = {3'd1, 4'd0, N_R, bs, T_R, im};
            end
            3'd4: u = (i == 0) ? {3'd1, 4'd0, N_R, SP_R, rd, NS}
                               : {3'd3, 4'd0, SP_R, SP_R, N_R, NS};
            3'd5: begin
                case (i)
                    0:       u = {3'd5, 4'd0, T_R, N_R, N_R, 32'd0};
                    1:       u = {3'd1, 4'd0, N_R, SP_R, T_R, NS};
                    2:       u = {3'd3, 4'd0, SP_R, SP_R, N_R, NS};
                    default: u = {3'd4, 4'd0, N_R, N_R, N_R, im};
                endcase
            end
            3'd6: begin
                case (i)
                    0:       u = {3'd3, 4'd0, SP_R, SP_R, N_R, PS};
                    1:       u = {3'd0, 4'd0, T_R, SP_R, N_R, NS};
                    default: u = {3'd4, 4'd0, N_R, T_R, N_R, 32'd0};
                endcase
            end
            default: begin
                case (i)
                    0:       u = {3'd0, 4'd0, T_R, bs, N_R, 32'd0};
                    1:       u = {3'd1, 4'd0, N_R, rd, T_R, 32'd0};
                    2:       u = {3'd3, 4'd0, bs, bs, N_R, PS};
                    3:       u = {3'd3, 4'd0, rd, rd, N_R, PS};
                    default: u = {3'd3, 4'd0, rs, rs, N_R, 32'hFFFF_FFFF};
                endcase
            end
        endcase
        return {u, (i == exp_len(v) - 1)};
    endfunction

    function automatic logic [54:0] got_uop();
        return {out_kind, out_aluop, out_dst, out_srca, out_srcb, out_imm, out_last};
    endfunction

    task automatic check(input string req, input string what, input logic [54:0] act, input logic [54:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [51:0] v);
        in_class  = v[51:49];
        in_aluop  = v[48:45];
        in_rd     = v[44:41];
        in_rs     = v[40:37];
        in_base   = v[36:33];
        in_memdst = v[32];
        in_imm    = v[31:0];
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // offer a record, wait until taken; returns at the negedge where uop 0 is shown
    task automatic send(input logic [51:0] v);
        @(negedge clk);
        drive(v);
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input logic [51:0] v, input string req);
        for (int i = 0; i < exp_len(v); i++) begin
            check(req, $sformatf("uop %0d valid", i), 55'(out_valid), 55'(1));
            check(req, $sformatf("uop %0d fields", i), got_uop(), exp_uop(v, i));
            @(negedge clk);
        end
        check("R12", "idle after last", 55'(out_valid), 55'(0));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual hang expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b1;
        drive('0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "out_valid after reset", 55'(out_valid), 55'(0));
        check("R1", "in_ready after reset", 55'(in_ready), 55'(1));

        // table walk over every class
        for (int k = 0; k < NVEC; k++) begin
            send(VECS[k]);
            drain(VECS[k], req_tag(VECS[k]));
        end

        // R4: temporary code on memory-source load
        send(VECS[3]);
        check("R4", "temporary register code", 55'(out_dst), 55'(5'd16));
        check("R4", "unused srcb is none", 55'(out_srcb), 55'(5'd31));
        @(negedge clk);
        @(negedge clk);

        // R2 / R3: call under backpressure
        out_ready = 1'b0;
        send(VECS[6]);
        check("R2", "in_ready low mid-sequence", 55'(in_ready), 55'(0));
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            check("R3", "held under stall", got_uop(), exp_uop(VECS[6], 0));
            check("R3", "valid under stall", 55'(out_valid), 55'(1));
        end
        out_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            check("R9", $sformatf("stalled call uop %0d", i), got_uop(), exp_uop(VECS[6], i));
            if (i < 3) check("R2", "in_ready low before last", 55'(in_ready), 55'(0));
            @(negedge clk);
        end
        check("R12", "idle after stalled call", 55'(out_valid), 55'(0));

        // R13: back-to-back single micro-op records
        drive(VECS[0]);
        in_valid = 1'b1;
        @(negedge clk);
        check("R13", "first record uop", got_uop(), exp_uop(VECS[0], 0));
        check("R13", "ready during last accept", 55'(in_ready), 55'(1));
        drive(VECS[9]);
        @(negedge clk);
        in_valid = 1'b0;
        check("R13", "second record follows at once", got_uop(), exp_uop(VECS[9], 0));
        check("R13", "second record valid", 55'(out_valid), 55'(1));
        @(negedge clk);
        check("R12", "idle after back-to-back", 55'(out_valid), 55'(0));

        // R1: reset mid-sequence returns to idle
        send(VECS[8]);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "out_valid after mid-sequence reset", 55'(out_valid), 55'(0));
        check("R1", "in_ready after mid-sequence reset", 55'(in_ready), 55'(1));

        summary();
        $finish;
    end

endmodule